// File: doc/BRIEF.md
# Quad-Precision Floating-Point Comparator

This block orders two 128-bit binary128 floating-point operands without subtracting them. Each operand is split into a sign bit, a 15-bit exponent and a 112-bit fraction. The block then classifies the pair as equal, less, greater or unordered. Positive and negative zero compare as equal. When either operand is a NaN the pair is unordered. In that case an invalid-operation flag may be raised, depending on whether the comparison runs in quiet or signaling mode.

The two-bit condition code is written into a status register. The field that receives it is picked by a two-bit selector, and every other status bit is left as it was. The selected field is either the primary field or one of three extra fields. The result appears one clock after a start strobe, together with a one-cycle done pulse. If the invalid flag is raised while the trap enable is set, a trap request is raised alongside it.

Top module: `quad_fp_compare`

## Requirements
- R1: The selector `fld_sel` routes the code to a status field: 0 to bits 11:10, 1 to bits 23:22, 2 to bits 25:24 and 3 to bits 27:26.
- R2: A comparison changes only the selected field. While `start` is low, the status register holds its value.
- R3: An operand is a NaN when its exponent (bits 126:112) is all ones and its fraction (bits 111:0) is nonzero. If either operand is a NaN the code is 3 (unordered). An infinity is not a NaN.
- R4: In signaling mode (`sig_mode`=1), `invalid` is raised whenever either operand is a NaN.
- R5: In quiet mode (`sig_mode`=0), `invalid` is raised only when an operand is a signaling NaN, that is a NaN with fraction bit 111 clear.
- R6: Two zeros compare equal (code 0) whatever their sign bits (bit 127).
- R7: With differing signs and at least one nonzero operand, the operand with sign bit 0 is greater. The code is 2 when `op_a` is that operand and 1 otherwise.
- R8: With equal signs, identical operands give code 0. Otherwise the unsigned comparison of the full 128-bit words decides: code 1 if `op_a` is smaller, else 2. The outcome is inverted when both operands are negative.
- R9: `done` pulses high exactly one cycle after each cycle in which `start` is high. `invalid` and `trap_req` are high only in such cycles.
- R10: `trap_req` equals `invalid` when `trap_en` was high with the start strobe, and is low otherwise.
- R11: Reset clears the status register, `done`, `invalid` and `trap_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch a comparison this cycle |
| sig_mode | input | 1 | 1 = signaling compare, 0 = quiet compare |
| fld_sel | input | 2 | Destination condition field |
| trap_en | input | 1 | Invalid-operation trap enable |
| op_a | input | 128 | First operand |
| op_b | input | 128 | Second operand |
| status | output | 32 | Status register holding the condition fields |
| done | output | 1 | Result valid pulse |
| invalid | output | 1 | Invalid-operation flag for the finished compare |
| trap_req | output | 1 | Trap request for the finished compare |

## Verification
Every result (the written field, the unchanged rest of the status word, `invalid`, `trap_req` and `done`) is due at the first rising edge after the cycle in which `start` is high. The bench drives operands and strobe on the falling edge. It samples all outputs at the next falling edge, half a cycle after the register update, and checks the code and the whole status word against its own model of the field layout. The bench also checks that `done` drops one cycle later. It checks that strobes held high on back-to-back cycles each land in their own field, and that operands changed with the strobe low leave every output untouched.

// File: rtl/quad_fp_compare.sv
module quad_fp_compare #(
  parameter int EXP_W  = 15,
  parameter int FRAC_W = 112,
  parameter int STAT_W = 32,
  parameter int F0_LSB = 10,
  parameter int F1_LSB = 22,
  parameter int F2_LSB = 24,
  parameter int F3_LSB = 26
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic                      sig_mode,
  input  logic [1:0]                fld_sel,
  input  logic                      trap_en,
  input  logic [EXP_W+FRAC_W:0]     op_a,
  input  logic [EXP_W+FRAC_W:0]     op_b,
  output logic [STAT_W-1:0]         status,
  output logic                      done,
  output logic                      invalid,
  output logic                      trap_req
);

  localparam int OP_W = 1 + EXP_W + FRAC_W;
  localparam logic [1:0] CC_EQ = 2'd0;
  localparam logic [1:0] CC_LT = 2'd1;
  localparam logic [1:0] CC_GT = 2'd2;
  localparam logic [1:0] CC_UN = 2'd3;

  function automatic int flsb(input logic [1:0] s);
    case (s)
      2'd0:    flsb = F0_LSB;
      2'd1:    flsb = F1_LSB;
      2'd2:    flsb = F2_LSB;
      default: flsb = F3_LSB;
    endcase
  endfunction

  function automatic logic [STAT_W-1:0] fmask(input logic [1:0] s);
    fmask = STAT_W'(2'b11) << flsb(s);
  endfunction

  logic sign_a, sign_b, nan_a, nan_b, snan_a, snan_b;
  logic zero_pair, same_bits, mag_lt, nan_any, inv_now;
  logic [1:0] cc;
  logic [STAT_W-1:0] status_nxt;

  assign sign_a = op_a[OP_W-1];
  assign sign_b = op_b[OP_W-1];
  assign nan_a  = (&op_a[OP_W-2 -: EXP_W]) && (|op_a[FRAC_W-1:0]);
  assign nan_b  = (&op_b[OP_W-2 -: EXP_W]) && (|op_b[FRAC_W-1:0]);
  assign snan_a = nan_a && !op_a[FRAC_W-1];
  assign snan_b = nan_b && !op_b[FRAC_W-1];
  assign nan_any = nan_a || nan_b;

  assign zero_pair = ~|{op_a[OP_W-2:0], op_b[OP_W-2:0]};
  assign same_bits = (op_a == op_b);
  assign mag_lt    = (op_a < op_b);

  always_comb begin
    if (nan_any)
      cc = CC_UN;
    else if (sign_a != sign_b)
      cc = zero_pair ? CC_EQ : (sign_a ? CC_LT : CC_GT);
    else if (same_bits)
      cc = CC_EQ;
    else
      cc = (mag_lt ^ sign_a) ? CC_LT : CC_GT;
  end

  assign inv_now    = sig_mode ? nan_any : (snan_a || snan_b);
  assign status_nxt = (status & ~fmask(fld_sel)) | (STAT_W'(cc) << flsb(fld_sel));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status   <= '0;
      done     <= 1'b0;
      invalid  <= 1'b0;
      trap_req <= 1'b0;
    end else begin
      done     <= start;
      invalid  <= start && inv_now;
      trap_req <= start && inv_now && trap_en;
      if (start)
        status <= status_nxt;
    end
  end

  assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(status));

  assert_other_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (((status ^ $past(status)) & ~fmask($past(fld_sel))) == '0));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);

  assert_done_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done);

  assert_inv_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    invalid |-> done);

  assert_trap_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> (invalid && $past(trap_en)));

  assert_inv_unordered_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && invalid) |-> (status[flsb($past(fld_sel)) +: 2] == CC_UN));

endmodule

// File: tb/quad_fp_compare_bench.sv
`timescale 1ns/1ps
module quad_fp_compare_bench;

  localparam logic [127:0] PZ   = 128'h0000_0000_0000_0000_0000_0000_0000_0000;
  localparam logic [127:0] NZ   = 128'h8000_0000_0000_0000_0000_0000_0000_0000;
  localparam logic [127:0] ONE  = 128'h3FFF_0000_0000_0000_0000_0000_0000_0000;
  localparam logic [127:0] ONEP = 128'h3FFF_0000_0000_0000_0000_0000_0000_0001;
  localparam logic [127:0] TWO  = 128'h4000_0000_0000_0000_0000_0000_0000_0000;
  localparam logic [127:0] QNAN = 128'h7FFF_8000_0000_0000_0000_0000_0000_0000;
  localparam logic [127:0] SNAN = 128'h7FFF_0000_0000_0000_0000_0000_0000_0001;
  localparam logic [127:0] INF  = 128'h7FFF_0000_0000_0000_0000_0000_0000_0000;

  typedef struct packed {
    logic [127:0] a;
    logic [127:0] b;
    logic         sig;
    logic [1:0]   cc;
    logic         inv;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{ONE,        TWO,        1'b0, 2'd1, 1'b0},  // R8 positive less
    '{TWO,        ONE,        1'b0, 2'd2, 1'b0},  // R8 positive greater
    '{ONE,        ONE,        1'b1, 2'd0, 1'b0},  // R8 identical
    '{ONE | NZ,   TWO | NZ,   1'b0, 2'd2, 1'b0},  // R8 negative inverted
    '{TWO | NZ,   ONE | NZ,   1'b0, 2'd1, 1'b0},  // R8 negative inverted
    '{ONEP,       ONE,        1'b0, 2'd2, 1'b0},  // R8 lowest bit decides
    '{PZ,         NZ,         1'b1, 2'd0, 1'b0},  // R6
    '{NZ,         PZ,         1'b0, 2'd0, 1'b0},  // R6
    '{ONE,        TWO | NZ,   1'b0, 2'd2, 1'b0},  // R7
    '{ONE | NZ,   PZ,         1'b0, 2'd1, 1'b0},  // R7
    '{QNAN,       ONE,        1'b0, 2'd3, 1'b0},  // R3 R5 quiet NaN no flag
    '{ONE,        SNAN,       1'b0, 2'd3, 1'b1},  // R5 signaling NaN flags
    '{QNAN,       ONE,        1'b1, 2'd3, 1'b1},  // R4
    '{TWO,        SNAN | NZ,  1'b1, 2'd3, 1'b1},  // R4
    '{INF,        TWO,        1'b1, 2'd2, 1'b0},  // R3 infinity ordered
    '{INF,        INF,        1'b1, 2'd0, 1'b0},  // R3
    '{INF | NZ,   INF,        1'b0, 2'd1, 1'b0},  // R7
    '{QNAN | NZ,  QNAN,       1'b0, 2'd3, 1'b0}   // R5
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, sig_mode = 1'b0, trap_en = 1'b0;
  logic [1:0] fld_sel = 2'd0;
  logic [127:0] op_a = '0, op_b = '0;
  logic [31:0] status;
  logic done, invalid, trap_req;

  int total = 0, fails = 0;
  logic [31:0] model = '0;

  always #2 clk = ~clk;

  quad_fp_compare u_quad_fp_compare (
    .clk(clk), .rst_n(rst_n), .start(start), .sig_mode(sig_mode),
    .fld_sel(fld_sel), .trap_en(trap_en), .op_a(op_a), .op_b(op_b),
    .status(status), .done(done), .invalid(invalid), .trap_req(trap_req)
  );

  function automatic int lsb_of(input logic [1:0] s);
    case (s)
      2'd0: return 10;
      2'd1: return 22;
      2'd2: return 24;
      default: return 26;
    endcase
  endfunction

  function automatic logic [31:0] put(input logic [31:0] m, input logic [1:0] s, input logic [1:0] c);
    logic [31:0] r;
    r = m;
    r[lsb_of(s) +: 2] = c;
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  task automatic launch(input logic [127:0] a, input logic [127:0] b, input logic sg,
                        input logic [1:0] s, input logic te);
    @(negedge clk);
    op_a = a; op_b = b; sig_mode = sg; fld_sel = s; trap_en = te; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(status == '0, "R11 status", status, 0);
    chk({done, invalid, trap_req} == 3'b000, "R11 flags", {done, invalid, trap_req}, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [1:0] s;
      logic te;
      s  = 2'(i % 4);
      te = (i % 3) != 0;
      launch(VEC[i].a, VEC[i].b, VEC[i].sig, s, te);
      model = put(model, s, VEC[i].cc);
      chk(status[lsb_of(s) +: 2] == VEC[i].cc, "R1 R3 R6 R7 R8 code", status[lsb_of(s) +: 2], VEC[i].cc);
      chk(status == model, "R2 status word", status, model);
      chk(invalid == VEC[i].inv, "R4 R5 invalid", invalid, VEC[i].inv);
      chk(trap_req == (VEC[i].inv && te), "R10 trap", trap_req, VEC[i].inv && te);
      chk(done == 1'b1, "R9 done", done, 1);
      @(negedge clk);
      chk({done, invalid, trap_req} == 3'b000, "R9 done drops", {done, invalid, trap_req}, 0);
    end

    // R2 idle: operands change with start low, nothing moves
    op_a = SNAN; op_b = QNAN; sig_mode = 1'b1; trap_en = 1'b1; fld_sel = 2'd2;
    repeat (3) @(negedge clk);
    chk(status == model, "R2 idle hold", status, model);
    chk({done, invalid, trap_req} == 3'b000, "R9 idle flags", {done, invalid, trap_req}, 0);

    // R1 R9 back-to-back strobes into distinct fields
    @(negedge clk);
    op_a = ONE; op_b = TWO; sig_mode = 1'b0; fld_sel = 2'd0; trap_en = 1'b0; start = 1'b1;
    @(negedge clk);
    model = put(model, 2'd0, 2'd1);
    chk(status == model, "R1 first of pair", status, model);
    chk(done, "R9 first done", done, 1);
    op_a = SNAN; op_b = ONE; fld_sel = 2'd3; trap_en = 1'b1;
    @(negedge clk);
    start = 1'b0;
    model = put(model, 2'd3, 2'd3);
    chk(status == model, "R1 second of pair", status, model);
    chk(done && invalid && trap_req, "R10 second trap", {done, invalid, trap_req}, 3'b111);
    @(negedge clk);
    chk(!done, "R9 done after pair", done, 0);

    // R11 reset clears a populated register
    chk(status != '0, "R11 precondition", status, model);
    rst_n = 1'b0;
    @(negedge clk);
    chk(status == '0, "R11 status cleared", status, 0);
    chk({done, invalid, trap_req} == 3'b000, "R11 flags cleared", {done, invalid, trap_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    summary();
  end

endmodule